// File: doc/BRIEF.md
# Memory Range CRC32 Checksum Sequencer

The block computes a CRC-32 over a contiguous, page-aligned region of on-chip flash and reports when the result is valid. Software writes one 32-bit control word carrying a start page number (pages are 4 KB) and a size code. The sequencer derives the word range, streams it through a synchronous read port at one word per clock, folds each word into the checksum and raises a ready flag together with the final value.

The region's last page is formed by OR-ing a mask of `code` low-order ones into the start page, not by adding a length. An aligned start therefore covers 2^code pages. An unaligned start is cut off at the end of the power-of-two block that encloses it. The sequencer rejects and flags a request whose size code is unsupported or whose region reaches past the configured flash. A new accepted request aborts a running one.

Top module: `crc_range_seq`

## Requirements
- R1: After reset, `ready` is 0, `crc_result` is 0, `ctrl_rdata` is 0, `cfg_err` is 0 and `mem_re` is 0.
- R2: `ctrl_rdata` returns the last accepted start page in bits 15:0 and its size code in bits 19:16, with the ready flag in bit 24. Every other bit reads 0, whatever was written there.
- R3: For page P and code C, the first word address read is P*1024. The last is ((P | (2^C − 1)) * 1024) + 1023, so an unaligned start is clipped to its enclosing 2^C-page block.
- R4: Reads are issued on consecutive cycles at ascending consecutive word addresses. Exactly (last − first + 1) reads are made for one sequence.
- R5: `crc_result` is the CRC-32 of the region: polynomial 0x04C11DB7, reflected, initial value 0xFFFFFFFF, final XOR 0xFFFFFFFF. Each word is fed least-significant byte first, and read data arrives one cycle after its read.
- R6: An accepted write drops `ready` to 0 on the next cycle. `ready` returns to 1 in the same cycle that `crc_result` takes the new value.
- R7: A write with a size code above 10 (bits 19:16 in 11..15) sets `cfg_err` and starts no reads. It leaves `ready`, `crc_result` and `ctrl_rdata` unchanged.
- R8: A write whose last page (P | mask) is at or beyond FLASH_PAGES is rejected like R7.
- R9: An accepted write during a running sequence abandons it. The result then covers only the new region.
- R10: `crc_result` holds its value until the next sequence completes. An accepted write clears `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: page in bits 15:0, size code in bits 19:16 |
| ctrl_rdata | output | 32 | Control word readback with ready flag in bit 24 |
| cfg_err | output | 1 | Last write was rejected |
| ready | output | 1 | Checksum result valid |
| crc_result | output | 32 | Last completed checksum |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | AW | Memory word address |
| mem_rdata | input | 32 | Read data, valid one cycle after the request |

## Verification
A wrong address counter or end-of-range compare shows up in the read stream on the first cycle it goes wrong, as a skipped or extra address or a wrong read count. A lost or misaligned read-valid pipeline stage corrupts `crc_result` only when `ready` rises, one cycle after the last read. The bench therefore compares the read stream and the final value for every region. Errors in rejection and abort appear one cycle after the write, in `cfg_err`, `ready` and `mem_re`.

// File: rtl/crc_range_seq.sv
module crc_range_seq #(
  parameter int FLASH_PAGES = 4,
  parameter int MAX_CODE    = 10,
  localparam int PW = $clog2(FLASH_PAGES),
  localparam int AW = PW + 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   ctrl_rdata,
  output logic          cfg_err,
  output logic          ready,
  output logic [31:0]   crc_result,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata
);

  function automatic logic [31:0] fold(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 32; i++)
      r = (r >> 1) ^ (32'hEDB88320 & {32{r[0] ^ d[i]}});
    return r;
  endfunction

  logic [15:0] wr_page, wr_mask, wr_end;
  logic [3:0]  wr_code;
  logic        code_bad, range_bad, accept;

  assign wr_page   = cfg_wdata[15:0];
  assign wr_code   = cfg_wdata[19:16];
  assign wr_mask   = 16'((17'd1 << wr_code) - 17'd1);
  assign wr_end    = wr_page | wr_mask;
  assign code_bad  = 32'(wr_code) > MAX_CODE;
  assign range_bad = 32'(wr_end) >= FLASH_PAGES;
  assign accept    = cfg_we && !code_bad && !range_bad;

  logic [15:0]   page_q;
  logic [3:0]    code_q;
  logic [AW-1:0] addr, last;
  logic          issuing, rd_vld, rd_last;
  logic [31:0]   crc, crc_nxt;

  assign crc_nxt    = fold(crc, mem_rdata);
  assign mem_re     = issuing;
  assign mem_addr   = addr;
  assign ctrl_rdata = {7'b0, ready, 4'b0, code_q, page_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q     <= '0;
      code_q     <= '0;
      addr       <= '0;
      last       <= '0;
      issuing    <= 1'b0;
      rd_vld     <= 1'b0;
      rd_last    <= 1'b0;
      crc        <= '1;
      crc_result <= '0;
      ready      <= 1'b0;
      cfg_err    <= 1'b0;
    end else begin
      if (cfg_we) cfg_err <= !accept;
      if (accept) begin
        page_q  <= wr_page;
        code_q  <= wr_code;
        addr    <= {wr_page[PW-1:0], 10'h000};
        last    <= {wr_end[PW-1:0], 10'h3FF};
        issuing <= 1'b1;
        rd_vld  <= 1'b0;
        rd_last <= 1'b0;
        crc     <= '1;
        ready   <= 1'b0;
      end else begin
        rd_vld  <= issuing;
        rd_last <= issuing && (addr == last);
        if (issuing) begin
          addr <= addr + 1'b1;
          if (addr == last) issuing <= 1'b0;
        end
        if (rd_vld) begin
          crc <= crc_nxt;
          if (rd_last) begin
            crc_result <= ~crc_nxt;
            ready      <= 1'b1;
          end
        end
      end
    end
  end

endmodule

module crc_range_seq_chk #(parameter int AW = 12) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [31:0]   cfg_wdata,
  input logic          accept,
  input logic          mem_re,
  input logic [AW-1:0] mem_addr,
  input logic          ready,
  input logic [31:0]   crc_result,
  input logic          cfg_err
);
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !accept) |=> (!mem_re || mem_addr == $past(mem_addr) + 1'b1));
  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);
  // R6
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !mem_re);
  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[19:16] > 4'd10) |=> cfg_err);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !accept) |=> $stable(crc_result));
endmodule

bind crc_range_seq crc_range_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .accept(accept), .mem_re(mem_re), .mem_addr(mem_addr), .ready(ready),
  .crc_result(crc_result), .cfg_err(cfg_err)
);

// File: tb/sim_crc_range_seq.sv
module sim_crc_range_seq;
  localparam int PAGES = 4;
  localparam int AW = $clog2(PAGES) + 10;
  localparam int WORDS = PAGES * 1024;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [31:0] cfg_wdata = 0, ctrl_rdata, crc_result, mem_rdata;
  logic cfg_err, ready, mem_re;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem [WORDS];

  int errors = 0, checks = 0;
  int rd_cnt = 0, rd_first = 0, rd_prev = 0, rd_gap = 0;

  always #4 clk = ~clk;

  crc_range_seq #(.FLASH_PAGES(PAGES)) u0 (.*);

  always_ff @(posedge clk) if (mem_re) mem_rdata <= mem[mem_addr];

  always @(posedge clk) if (mem_re) begin
    if (rd_cnt == 0) rd_first = int'(mem_addr);
    else if (int'(mem_addr) != rd_prev + 1) rd_gap++;
    rd_prev = int'(mem_addr);
    rd_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int first, input int lastw);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = first; w <= lastw; w++)
      for (int b = 0; b < 32; b++) begin
        logic fb = c[0] ^ mem[w][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk); cfg_we = 1; cfg_wdata = w;
    @(negedge clk); cfg_we = 0;
    rd_cnt = 0; rd_gap = 0;
  endtask

  task automatic wait_ready(output bit ok);
    ok = 0;
    for (int i = 0; i < 6000; i++) begin
      if (ready) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input int page, input int code, input logic [7:0] junk);
    int endp, first, lastw;
    bit ok;
    logic [31:0] exp, held;
    endp  = page | ((1 << code) - 1);
    first = page * 1024;
    lastw = endp * 1024 + 1023;
    wr({junk[6:0], junk[7], 4'hF & junk[3:0], code[3:0], page[15:0]});
    chk("R6 ready low after write", 32'(ready), 0);
    chk("R10 err cleared", 32'(cfg_err), 0);
    exp = ref_crc(first, lastw);
    wait_ready(ok);
    chk("R6 completes", 32'(ok), 1);
    chk("R5 crc", crc_result, exp);
    chk("R4 read count", rd_cnt, lastw - first + 1);
    chk("R4 contiguous", rd_gap, 0);
    chk("R3 first addr", rd_first, first);
    chk("R3 last addr", rd_prev, lastw);
    chk("R2 ctrl readback", ctrl_rdata, {7'b0, 1'b1, 4'b0, code[3:0], page[15:0]});
    held = crc_result;
    repeat (5) @(negedge clk);
    chk("R10 result held", crc_result, held);
  endtask

  task automatic reject(input int page, input int code, input string req);
    logic [31:0] c0, r0;
    logic rd0;
    c0 = ctrl_rdata; r0 = crc_result; rd0 = ready;
    wr({12'h0, code[3:0], page[15:0]});
    chk({req, " err set"}, 32'(cfg_err), 1);
    chk({req, " no read"}, 32'(mem_re), 0);
    repeat (3) @(negedge clk);
    chk({req, " no reads"}, rd_cnt, 0);
    chk({req, " ready kept"}, 32'(ready), 32'(rd0));
    chk({req, " result kept"}, crc_result, r0);
    chk({req, " ctrl kept"}, ctrl_rdata, c0);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 result", crc_result, 0);
    chk("R1 ctrl", ctrl_rdata, 0);
    chk("R1 err", 32'(cfg_err), 0);
    chk("R1 mem_re", 32'(mem_re), 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 0, 8'hFF);
    run(2, 1, 8'h5A);
    run(3, 1, 8'h00);   // R3 unaligned start clipped to page 3
    run(1, 1, 8'hA5);   // R3 clipped to page 1
    run(0, 2, 8'h3C);
    reject(0, 11, "R7 code 11");
    reject(1, 15, "R7 code 15");
    reject(4, 0, "R8 page 4");
    reject(0, 3, "R8 code 3");
    reject(16'h8000, 0, "R8 high page");
    for (int k = 0; k < 6; k++) begin
      int c = int'($urandom_range(0, 1));
      int p = int'($urandom_range(0, PAGES - 1));
      run(p, c, 8'($urandom));
    end
    // R9 abort and restart
    wr({12'h0, 4'd2, 16'd0});
    repeat (100) @(negedge clk);
    run(1, 0, 8'h00);
    chk("R9 restart read count", rd_cnt, 1024);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule